// File: doc/BRIEF.md
# Ethernet receive frame assembler

This block turns a bare received Ethernet payload into the complete on-wire byte image and writes that image into a byte-addressed frame buffer. Payload bytes arrive on a valid/ready/last stream. When the first byte of a frame is offered, the block lays down the eight-byte preamble and start delimiter. It then accepts the payload and places it behind that header, zero-fills short payloads up to the 60-byte minimum, and finishes with a CRC-32 over the padded payload.

After the last check byte is in the buffer, a one-cycle done pulse reports the total image length: the padded payload length plus 12. A payload whose image would not fit the buffer is rejected. It is written only as far as the buffer allows, the rest of it is drained from the stream, and done then reports length zero together with an error flag. The buffer write port is driven combinationally from the block state and the current input byte, so every byte lands in the cycle it is produced.

Top module: `rx_frame_builder`

## Requirements
- R1: After reset, wr_en, done and error are low, frame_len is zero and in_ready is low.
- R2: For each frame, bytes 0x55 are written to offsets 0 to 6 and 0xD5 to offset 7, in that order, before any payload byte is written.
- R3: Payload byte k (counting from 0 in arrival order) is written to offset 8+k in the cycle it is accepted, whatever idle gaps occur on in_valid.
- R4: When the payload has fewer than 60 bytes, zero bytes are written at the following offsets until 60 payload bytes are in place; payloads of 60 bytes or more get no padding.
- R5: A CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, final inversion) over the padded payload only is written as four bytes, least significant first, at the offsets that directly follow the padded payload.
- R6: done is a one-cycle pulse in the cycle after the last check byte is written, with frame_len equal to the padded payload length plus 12 and error low.
- R7: A payload longer than BUF_BYTES-12 bytes (2036 by default) has only its first 2036 bytes written, and no padding or check bytes. The remaining bytes are consumed and discarded up to the last one, and done follows in the next cycle with frame_len zero and error high.
- R8: in_ready is low while idle and while the header, padding or check bytes are written; a byte is consumed only when in_valid and in_ready are both high.
- R9: frame_len and error keep their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Offered byte is the final payload byte |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 11 | Buffer byte offset |
| wr_data | output | 8 | Buffer write byte |
| done | output | 1 | One-cycle frame completion pulse |
| frame_len | output | 12 | Total image length of the last frame, zero on reject |
| error | output | 1 | Last frame was rejected as too large |

## Verification
The first header write is due one cycle after a frame's first byte is offered to the idle block. Each payload write appears in the same cycle as its acceptance, and padding and check bytes follow one per cycle with no gap. done is due exactly one cycle after the last check byte is written, or, for a rejected frame, one cycle after its last byte is accepted. A behavioural model in the bench queues the expected address and data of every write and, 1 ns after each falling edge, compares the write port, done, frame_len and error with what is due in that very cycle. Any write or done pulse that is not due is therefore caught as well as any that is missing.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_PAY, ST_PAD, ST_CRC, ST_DROP, ST_DONE
  } st_t;

  typedef enum logic [1:0] {
    SRC_PRE, SRC_PAY, SRC_ZERO, SRC_CRC
  } src_t;

  localparam int          PRE_LEN  = 8;
  localparam int          CRC_LEN  = 4;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  // one byte of reflected CRC-32, lsb first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rfb_crc.sv
module rfb_crc
  import rfb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] fin
);

  logic [31:0] crc_q, crc_d;
  logic        crc_ce;

  always_comb begin
    crc_ce = clr | en;
    if (clr) crc_d = CRC_INIT;
    else     crc_d = crc_step(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_INIT;
    else if (crc_ce) crc_q <= crc_d;
  end

  assign fin = ~crc_q;

  // R5
  clr_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !clr);

endmodule

// File: rtl/rfb_wmux.sv
module rfb_wmux
  import rfb_pkg::*;
(
  input  src_t        src,
  input  logic [2:0]  idx,
  input  logic [7:0]  in_data,
  input  logic [31:0] crc_fin,
  output logic [7:0]  byte_out
);

  logic [31:0] crc_sh;

  always_comb begin
    crc_sh = crc_fin >> {idx[1:0], 3'b000};
    unique case (src)
      SRC_PRE:  byte_out = (idx == 3'd7) ? SFD_BYTE : PRE_BYTE;
      SRC_PAY:  byte_out = in_data;
      SRC_ZERO: byte_out = 8'h00;
      default:  byte_out = crc_sh[7:0];
    endcase
  end

endmodule

// File: rtl/rfb_ctrl.sv
module rfb_ctrl
  import rfb_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_PAY   = 60,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int LEN_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output src_t              src,
  output logic [2:0]        idx,
  output logic              crc_clr,
  output logic              crc_en,
  output logic              done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              error
);

  localparam int MAX_PAY = BUF_BYTES - PRE_LEN - CRC_LEN;

  st_t              st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [2:0]       idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             err_q, err_d, res_ce;
  logic [LEN_W-1:0] addr_full;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    len_d    = len_q;
    err_d    = err_q;
    res_ce   = 1'b0;
    in_ready = 1'b0;
    wr_en    = 1'b0;
    src      = SRC_PRE;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    cnt_inc  = cnt_q + LEN_W'(1);
    unique case (st_q)
      ST_IDLE: begin
        crc_clr = 1'b1;
        if (in_valid) begin
          st_d  = ST_PRE;
          idx_d = 3'd0;
        end
      end
      ST_PRE: begin
        wr_en = 1'b1;
        idx_d = idx_q + 3'd1;
        if (idx_q == 3'd7) begin
          st_d  = ST_PAY;
          cnt_d = '0;
        end
      end
      ST_PAY: begin
        in_ready = 1'b1;
        src      = SRC_PAY;
        if (in_valid) begin
          if (cnt_q == LEN_W'(MAX_PAY)) begin
            if (in_last) begin
              st_d = ST_DONE; len_d = '0; err_d = 1'b1; res_ce = 1'b1;
            end else begin
              st_d = ST_DROP;
            end
          end else begin
            wr_en  = 1'b1;
            crc_en = 1'b1;
            cnt_d  = cnt_inc;
            if (in_last) begin
              idx_d = 3'd0;
              st_d  = (cnt_inc < LEN_W'(MIN_PAY)) ? ST_PAD : ST_CRC;
            end
          end
        end
      end
      ST_PAD: begin
        src    = SRC_ZERO;
        wr_en  = 1'b1;
        crc_en = 1'b1;
        cnt_d  = cnt_inc;
        if (cnt_inc == LEN_W'(MIN_PAY)) st_d = ST_CRC;
      end
      ST_CRC: begin
        src   = SRC_CRC;
        wr_en = 1'b1;
        idx_d = idx_q + 3'd1;
        if (idx_q == 3'd3) begin
          st_d   = ST_DONE;
          len_d  = cnt_q + LEN_W'(PRE_LEN + CRC_LEN);
          err_d  = 1'b0;
          res_ce = 1'b1;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        src      = SRC_PAY;
        if (in_valid && in_last) begin
          st_d = ST_DONE; len_d = '0; err_d = 1'b1; res_ce = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    addr_full = (st_q == ST_PRE) ? LEN_W'(idx_q)
              : LEN_W'(PRE_LEN) + cnt_q + ((st_q == ST_CRC) ? LEN_W'(idx_q) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else if (res_ce) begin
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  assign wr_addr   = addr_full[ADDR_W-1:0];
  assign idx       = idx_q;
  assign done      = (st_q == ST_DONE);
  assign frame_len = len_q;
  assign error     = err_q;

  // R2
  pre_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && src == SRC_PRE) |-> wr_addr < ADDR_W'(PRE_LEN));
  // R8
  pay_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && src == SRC_PAY) |-> (in_valid && in_ready));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  good_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> frame_len >= LEN_W'(MIN_PAY + PRE_LEN + CRC_LEN));
  // R7
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> frame_len == '0);
  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(frame_len) && $stable(error)));

endmodule

// File: rtl/rx_frame_builder.sv
module rx_frame_builder
  import rfb_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int MIN_PAY   = 60,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [LEN_W-1:0]  frame_len,
  output logic              error
);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  src_t        src;
  logic [2:0]  idx;
  logic        crc_clr, crc_en;
  logic [31:0] crc_fin;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rfb_ctrl #(
    .BUF_BYTES (BUF_BYTES),
    .MIN_PAY   (MIN_PAY),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .src       (src),
    .idx       (idx),
    .crc_clr   (crc_clr),
    .crc_en    (crc_en),
    .done      (done),
    .frame_len (frame_len),
    .error     (error)
  );

  rfb_wmux u_wmux (
    .src      (src),
    .idx      (idx),
    .in_data  (in_data),
    .crc_fin  (crc_fin),
    .byte_out (wr_data)
  );

  rfb_crc u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .data  (wr_data),
    .fin   (crc_fin)
  );

endmodule

// File: tb/rx_frame_builder_test.sv
`timescale 1ns/1ps
module rx_frame_builder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [7:0]  in_data;
  logic        in_ready, wr_en, done, error;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic [11:0] frame_len;

  int checks = 0;
  int errors = 0;
  int frames_done = 0;
  int wd = 0;
  bit ovf_mode = 0;
  bit done_due = 0;
  bit running = 0;
  int exp_len = 0;
  bit exp_err = 0;
  int exp_addr_q[$];
  int exp_data_q[$];

  always #2 clk = ~clk;

  rx_frame_builder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .frame_len(frame_len), .error(error)
  );

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[i]) begin
      c = c ^ {24'h0, b[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired: cycles %0d expected below 150000", wd);
      summary();
    end
  end

  // per-cycle comparison with the behavioural model
  always @(negedge clk) begin
    #1;
    if (running) begin
      if (done_due) begin
        checks++;
        if (!done || frame_len != exp_len[11:0] || error != exp_err)
          begin errors++;
            $display("FAIL R6/R7 done=%0b len=%0d err=%0b expected done=1 len=%0d err=%0b",
                     done, frame_len, error, exp_len, exp_err); end
        done_due = 0;
        frames_done++;
      end else if (done) begin
        checks++; errors++;
        $display("FAIL R6 done=1 expected 0 (not due)");
      end
      if (wr_en) begin
        checks++;
        if (exp_addr_q.size() == 0) begin
          errors++;
          $display("FAIL R4/R7 write addr=%0d data=%02h expected no write", wr_addr, wr_data);
        end else begin
          int ea, ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          if (wr_addr != ea[10:0] || wr_data != ed[7:0]) begin
            errors++;
            $display("FAIL R2/R3/R4/R5 write addr=%0d data=%02h expected addr=%0d data=%02h",
                     wr_addr, wr_data, ea, ed);
          end
          if (exp_addr_q.size() == 0 && !ovf_mode) done_due = 1;
        end
      end
      if (ovf_mode && in_valid && in_ready && in_last) done_due = 1;
    end
  end

  task automatic send_frame(input int n, input int seed, input int gap);
    logic [7:0] pay[$];
    logic [31:0] c;
    int target;
    for (int k = 0; k < n; k++) pay.push_back(8'((seed + k * 7) ^ (k >> 3)));
    ovf_mode = (n > 2036);
    for (int k = 0; k < 8; k++) begin
      exp_addr_q.push_back(k); exp_data_q.push_back(k == 7 ? 8'hD5 : 8'h55);
    end
    for (int k = 0; k < n && k < 2036; k++) begin
      exp_addr_q.push_back(8 + k); exp_data_q.push_back(pay[k]);
    end
    if (!ovf_mode) begin
      while (pay.size() < 60) begin
        exp_addr_q.push_back(8 + pay.size()); exp_data_q.push_back(0);
        pay.push_back(8'h00);
      end
      c = ref_crc(pay);
      for (int k = 0; k < 4; k++) begin
        exp_addr_q.push_back(8 + pay.size() + k); exp_data_q.push_back(c[8*k +: 8]);
      end
      exp_len = pay.size() + 12; exp_err = 0;
    end else begin
      exp_len = 0; exp_err = 1;
    end
    target = frames_done + 1;
    for (int k = 0; k < n; k++) begin
      bit acc;
      if (gap != 0 && (k % 5) == 3)
        repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'((seed + k * 7) ^ (k >> 3));
      in_last  = (k == n - 1);
      forever begin
        acc = in_ready;
        @(posedge clk);
        if (acc) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    wait (frames_done == target);
    repeat (5) @(negedge clk);
    #1;
    checks++;
    if (frame_len != exp_len[11:0] || error != exp_err) begin
      errors++;
      $display("FAIL R9 len=%0d err=%0b expected len=%0d err=%0b", frame_len, error, exp_len, exp_err);
    end
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R8 in_ready=%0b expected 0 when idle", in_ready);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (wr_en !== 1'b0 || done !== 1'b0 || error !== 1'b0 || frame_len !== 12'd0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 wr_en=%0b done=%0b err=%0b len=%0d ready=%0b expected all zero",
               wr_en, done, error, frame_len, in_ready);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1;
    send_frame(1, 8'h11, 0);      // R4 heavy padding
    send_frame(59, 8'h22, 0);     // R4 one pad byte
    send_frame(60, 8'h33, 0);     // R4 no padding at the boundary
    send_frame(64, 8'h44, 2);     // R3 idle gaps on the input
    send_frame(300, 8'h55, 1);    // R5 longer payload
    send_frame(2036, 8'h66, 0);   // R6 image fills the buffer exactly
    send_frame(2037, 8'h77, 0);   // R7 one byte too many
    send_frame(2100, 8'h88, 3);   // R7 drained with gaps
    send_frame(45, 8'h99, 0);     // R2 recovery after reject
    running = 0;
    checks++;
    if (exp_addr_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending writes=%0d expected 0", exp_addr_q.size());
    end
    summary();
  end

endmodule